// File: doc/BRIEF.md
# Board Interrupt Aggregator with Control Registers

This block sits on the board control bus of a processor card. It collects level interrupts from five on-board sources: an I/O controller, the video vertical blank, a graphics engine and two serial ports. Each source has a bit in a status register. An enabled and routed status bit is latched into a separate cause register. Three processor interrupt lines each have their own routing mask. A line asserts as soon as live status, enable and its mask overlap. It releases only once none of its routed and enabled cause bits remain. Software acknowledges an interrupt by writing zeros to the enable register, or the bit goes away when its source deasserts.

The same register window holds plain storage: device reset controls, a display latch, a size word, watchdog and trackball words, a vertical-sync control word and a sticky CMOS write-unlock flag. Registers are 32 bits wide. The register number comes from bits [20:17] of the bus word offset. Reads are combinational and have no side effects. Writes take effect at the clock edge where `bus_wr` is high.

Each interrupt line is driven by a small two-state machine.
- State `LINE_QUIET` (line low) takes transition `T_RAISE` to `LINE_RAISED` when enable AND mask AND status is non-zero.
- State `LINE_RAISED` (line high) takes transition `T_DROP` back to `LINE_QUIET` when enable AND mask AND cause is zero.

Top module: `brd_irq_hub`

## Requirements
- R1: The register number is bus_off[20:17]. The numbers are:
  - 0 revision, 1 device reset, 2 vertical-sync control;
  - 3, 4 and 5 the routing masks of lines 0, 1 and 2;
  - 6 unused, 7 enable, 8 cause, 9 status;
  - 10 size, 11 display latch, 12 CMOS unlock, 13 watchdog, 14 trackball.
  Storage registers (1–5, 7, 10, 11, 13, 14) read back what was written. Number 6 reads zero and ignores writes. Cause and status ignore bus writes.
- R2: A read of register 0 returns 0x00000001, whatever was written to it.
- R3: Source i owns status/cause bit i: I/O controller 0, vertical blank 1, graphics 2, serial A 3, serial B 4. A rising source sets its status bit, readable one cycle after the input is sampled. A falling source clears its bit in both status and cause, on the same timing.
- R4: When enable AND mask(n) AND status is non-zero while `cpu_irq[n]` is low, `cpu_irq[n]` goes high on the next clock. On that same clock, enable AND (OR of all masks) AND status is OR-ed into cause.
- R5: A high `cpu_irq[n]` goes low on the next clock when enable AND mask(n) AND cause is zero. It stays high while that value is non-zero, even after the status bits behind it have been acknowledged on other paths.
- R6: A write to register 7 stores the merged value and clears every cause bit that is zero in it.
- R7: A write to register 2 that turns bit 0 from 1 to 0 clears bit 1 in both status and cause. It stays cleared until the vertical-blank source rises again. Bit 1 of register 2 drives `vsync_pol`.
- R8: A write merges per byte: byte k of the register changes only when `bus_be[k]` is set. Register 1 bits 0, 2 and 4 drive `dev_rst[0]` (I/O controller), `dev_rst[1]` (graphics) and `dev_rst[2]` (watchdog).
- R9: Any write to register 12 sets `cmos_wr_ok`. It stays set until reset, and register 12 reads it back in bit 0.
- R10: A synchronous `rst` clears every register, the line states, the source history and `cmos_wr_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_off | input | 21 | Bus word offset; bits [20:17] select the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data for the register selected by bus_off |
| src_irq | input | 5 | Level interrupt inputs from the five sources |
| cpu_irq | output | 3 | Processor interrupt lines |
| dev_rst | output | 3 | Device reset controls from register 1 |
| vsync_pol | output | 1 | Vertical-sync polarity select |
| cmos_wr_ok | output | 1 | Sticky CMOS write-unlock flag |

## Verification
The hardest situation to reach is a line that stays high while its status no longer justifies it. The line is held only by cause bits that are routed and enabled on another source. Meanwhile the source that raised it is acknowledged through the enable register. The stimulus routes two serial sources to the same line and raises both. It then writes an enable value with only one of them cleared, and checks that the line holds. A second enable write clears the other bit and must drop the line one cycle later. The vertical-sync clear is reached by first writing bit 0 high and then low while the vertical-blank source stays high. This proves the cleared status does not come back from the live level.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

    localparam int REG_W = 32;
    localparam int IDX_W = 4;
    localparam int NUM_IDX = 1 << IDX_W;
    localparam int BE_W = REG_W / 8;

    typedef enum logic [IDX_W-1:0] {
        IX_REV    = 4'd0,
        IX_DEVRST = 4'd1,
        IX_VSYNC  = 4'd2,
        IX_ROUTE0 = 4'd3,
        IX_ROUTE1 = 4'd4,
        IX_ROUTE2 = 4'd5,
        IX_HOLE   = 4'd6,
        IX_ENABLE = 4'd7,
        IX_CAUSE  = 4'd8,
        IX_STATUS = 4'd9,
        IX_SIZE   = 4'd10,
        IX_DISP   = 4'd11,
        IX_UNLOCK = 4'd12,
        IX_WDOG   = 4'd13,
        IX_TRACK  = 4'd14,
        IX_SPARE  = 4'd15
    } reg_ix_e;

    // source bit positions in status / cause
    localparam int SRC_IOC = 0;
    localparam int SRC_VBL = 1;
    localparam int SRC_GFX = 2;
    localparam int SRC_SPA = 3;
    localparam int SRC_SPB = 4;

    // which register numbers hold plain written storage
    localparam logic [NUM_IDX-1:0] STORE_MASK = 16'h6CBE;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    function automatic logic [REG_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
        logic [REG_W-1:0] m;
        for (int k = 0; k < BE_W; k++) begin
            m[k*8 +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
    import brd_irq_pkg::*;
#(
    parameter int NUM_LINES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic [IDX_W-1:0]     wr_ix,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [BE_W-1:0]      wr_be,
    input  logic [IDX_W-1:0]     rd_ix,
    input  logic [REG_W-1:0]     status_i,
    input  logic [REG_W-1:0]     cause_i,
    output logic [REG_W-1:0]     rd_data,
    output logic [REG_W-1:0]     enable_o,
    output logic [REG_W-1:0]     route_o [NUM_LINES],
    output logic [REG_W-1:0]     devrst_o,
    output logic [REG_W-1:0]     vsync_o,
    output logic                 unlocked_o,
    output logic                 en_wr_o,
    output logic [REG_W-1:0]     en_val_o,
    output logic                 vclr_o
);

    localparam int ROUTE_BASE = int'(IX_ROUTE0);

    logic [REG_W-1:0] store_q [NUM_IDX];
    logic             unlocked_q;
    logic [REG_W-1:0] byte_mask;
    logic [REG_W-1:0] merged;

    assign byte_mask = be_to_mask(wr_be);
    assign merged    = (store_q[wr_ix] & ~byte_mask) | (wr_data & byte_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IDX; i++) begin
                store_q[i] <= '0;
            end
            unlocked_q <= 1'b0;
        end else if (wr_stb) begin
            if (STORE_MASK[wr_ix]) begin
                store_q[wr_ix] <= merged;
            end
            if (reg_ix_e'(wr_ix) == IX_UNLOCK) begin
                unlocked_q <= 1'b1;
            end
        end
    end

    // side-band strobes towards the interrupt core
    assign en_wr_o  = wr_stb && (reg_ix_e'(wr_ix) == IX_ENABLE);
    assign en_val_o = merged;
    assign vclr_o   = wr_stb && (reg_ix_e'(wr_ix) == IX_VSYNC)
                      && store_q[IX_VSYNC][0] && !merged[0];

    assign enable_o   = store_q[IX_ENABLE];
    assign devrst_o   = store_q[IX_DEVRST];
    assign vsync_o    = store_q[IX_VSYNC];
    assign unlocked_o = unlocked_q;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_route
        assign route_o[n] = store_q[ROUTE_BASE + n];
    end

    always_comb begin
        unique case (reg_ix_e'(rd_ix))
            IX_REV:    rd_data = 32'h0000_0001;
            IX_CAUSE:  rd_data = cause_i;
            IX_STATUS: rd_data = status_i;
            IX_UNLOCK: rd_data = {{(REG_W-1){1'b0}}, unlocked_q};
            IX_HOLE:   rd_data = '0;
            IX_SPARE:  rd_data = '0;
            default:   rd_data = store_q[rd_ix];
        endcase
    end

endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core
    import brd_irq_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 vclr_i,
    input  logic                 en_wr_i,
    input  logic [REG_W-1:0]     en_val_i,
    input  logic [REG_W-1:0]     enable_i,
    input  logic [REG_W-1:0]     route_any_i,
    output logic [REG_W-1:0]     status_o,
    output logic [REG_W-1:0]     cause_o
);

    logic [NUM_SRC-1:0] src_q;
    logic [REG_W-1:0]   rise_w;
    logic [REG_W-1:0]   fall_w;
    logic [REG_W-1:0]   vclr_w;
    logic [REG_W-1:0]   keep_w;
    logic [REG_W-1:0]   status_q, status_n;
    logic [REG_W-1:0]   cause_q, cause_n;

    for (genvar i = 0; i < REG_W; i++) begin : g_edge
        if (i < NUM_SRC) begin : g_src
            assign rise_w[i] = src_i[i] & ~src_q[i];
            assign fall_w[i] = ~src_i[i] & src_q[i];
        end else begin : g_none
            assign rise_w[i] = 1'b0;
            assign fall_w[i] = 1'b0;
        end
    end

    always_comb begin
        vclr_w = '0;
        vclr_w[SRC_VBL] = vclr_i;
        keep_w = ~fall_w & ~vclr_w & (en_wr_i ? en_val_i : '1);
        status_n = (status_q | rise_w) & ~fall_w & ~vclr_w;
        cause_n  = (cause_q | (enable_i & route_any_i & status_q)) & keep_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= '0;
            status_q <= '0;
            cause_q  <= '0;
        end else begin
            src_q    <= src_i;
            status_q <= status_n;
            cause_q  <= cause_n;
        end
    end

    assign status_o = status_q;
    assign cause_o  = cause_q;

endmodule

// File: rtl/brd_line_fsm.sv
module brd_line_fsm
    import brd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pend_i,
    input  logic held_i,
    output logic irq_o
);

    line_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pend_i)  state_n = LINE_RAISED;  // T_RAISE
            LINE_RAISED: if (!held_i) state_n = LINE_QUIET;   // T_DROP
            default:     state_n = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LINE_QUIET;
        else     state_q <= state_n;
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub
    import brd_irq_pkg::*;
#(
    parameter int OFF_W     = 21,
    parameter int IDX_LSB   = 17,
    parameter int NUM_SRC   = 5,
    parameter int NUM_LINES = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [OFF_W-1:0]      bus_off,
    input  logic [REG_W-1:0]      bus_wdata,
    input  logic [BE_W-1:0]       bus_be,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [NUM_SRC-1:0]    src_irq,
    output logic [NUM_LINES-1:0]  cpu_irq,
    output logic [2:0]            dev_rst,
    output logic                  vsync_pol,
    output logic                  cmos_wr_ok
);

    logic [IDX_W-1:0] reg_ix;
    logic [REG_W-1:0] enable_w, devrst_w, vsync_w, en_val_w;
    logic [REG_W-1:0] route_w [NUM_LINES];
    logic [REG_W-1:0] route_any_w;
    logic [REG_W-1:0] status_q, cause_q;
    logic             en_wr_w, vclr_w;
    logic [NUM_LINES-1:0] pend_w, held_w;

    assign reg_ix = bus_off[IDX_LSB +: IDX_W];

    brd_ctl_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (bus_wr),
        .wr_ix      (reg_ix),
        .wr_data    (bus_wdata),
        .wr_be      (bus_be),
        .rd_ix      (reg_ix),
        .status_i   (status_q),
        .cause_i    (cause_q),
        .rd_data    (bus_rdata),
        .enable_o   (enable_w),
        .route_o    (route_w),
        .devrst_o   (devrst_w),
        .vsync_o    (vsync_w),
        .unlocked_o (cmos_wr_ok),
        .en_wr_o    (en_wr_w),
        .en_val_o   (en_val_w),
        .vclr_o     (vclr_w)
    );

    always_comb begin
        route_any_w = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            route_any_w = route_any_w | route_w[n];
        end
    end

    brd_irq_core #(.NUM_SRC(NUM_SRC)) u_core (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src_irq),
        .vclr_i      (vclr_w),
        .en_wr_i     (en_wr_w),
        .en_val_i    (en_val_w),
        .enable_i    (enable_w),
        .route_any_i (route_any_w),
        .status_o    (status_q),
        .cause_o     (cause_q)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign pend_w[n] = |(enable_w & route_w[n] & status_q);
        assign held_w[n] = |(enable_w & route_w[n] & cause_q);

        brd_line_fsm u_fsm (
            .clk    (clk),
            .rst    (rst),
            .pend_i (pend_w[n]),
            .held_i (held_w[n]),
            .irq_o  (cpu_irq[n])
        );
    end

    assign dev_rst   = {devrst_w[4], devrst_w[2], devrst_w[0]};
    assign vsync_pol = vsync_w[1];

endmodule

// File: rtl/brd_irq_hub_chk.sv
module brd_irq_hub_chk
    import brd_irq_pkg::*;
#(
    parameter int OFF_W     = 21,
    parameter int IDX_LSB   = 17,
    parameter int NUM_SRC   = 5,
    parameter int NUM_LINES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [OFF_W-1:0]     bus_off,
    input logic [REG_W-1:0]     bus_wdata,
    input logic [BE_W-1:0]      bus_be,
    input logic [REG_W-1:0]     bus_rdata,
    input logic [NUM_SRC-1:0]   src_irq,
    input logic [NUM_LINES-1:0] cpu_irq,
    input logic                 cmos_wr_ok,
    input logic [REG_W-1:0]     status_q,
    input logic [REG_W-1:0]     cause_q,
    input logic [NUM_LINES-1:0] pend_w,
    input logic [NUM_LINES-1:0] held_w
);

    AST_REV_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_off[IDX_LSB +: IDX_W] == IX_REV) |-> (bus_rdata == 32'h1)); // R2

    AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmos_wr_ok |=> cmos_wr_ok); // R9

    AST_ENABLE_ACK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_off[IDX_LSB +: IDX_W] == IX_ENABLE && bus_be == '1)
        |=> ((cause_q & ~$past(bus_wdata)) == '0)); // R6

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src_chk
        AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
            $fell(src_irq[k]) |=> (!status_q[k] && !cause_q[k])); // R3
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_chk
        AST_RAISE_NEXT: assert property (@(posedge clk) disable iff (rst)
            (!cpu_irq[n] && pend_w[n]) |=> cpu_irq[n]); // R4
        AST_DROP_NEXT: assert property (@(posedge clk) disable iff (rst)
            (cpu_irq[n] && !held_w[n]) |=> !cpu_irq[n]); // R5
        AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
            (cpu_irq[n] && held_w[n]) |=> cpu_irq[n]); // R5
    end

endmodule

bind brd_irq_hub brd_irq_hub_chk #(
    .OFF_W(OFF_W), .IDX_LSB(IDX_LSB), .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_off    (bus_off),
    .bus_wdata  (bus_wdata),
    .bus_be     (bus_be),
    .bus_rdata  (bus_rdata),
    .src_irq    (src_irq),
    .cpu_irq    (cpu_irq),
    .cmos_wr_ok (cmos_wr_ok),
    .status_q   (status_q),
    .cause_q    (cause_q),
    .pend_w     (pend_w),
    .held_w     (held_w)
);

// File: tb/test_brd_irq_hub.sv
module test_brd_irq_hub;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [20:0] bus_off;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata;
    logic [4:0]  src_irq;
    logic [2:0]  cpu_irq;
    logic [2:0]  dev_rst;
    logic        vsync_pol;
    logic        cmos_wr_ok;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    brd_irq_hub i_brd_irq_hub (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_off(bus_off),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .src_irq(src_irq), .cpu_irq(cpu_irq), .dev_rst(dev_rst),
        .vsync_pol(vsync_pol), .cmos_wr_ok(cmos_wr_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int ix, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1'b1; bus_off = 21'(ix) << 17; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input int ix, output logic [31:0] d);
        bus_off = 21'(ix) << 17;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_wr = 1'b0; bus_off = '0; bus_wdata = '0; bus_be = '0; src_irq = '0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        check("R10 irq after reset", {29'b0, cpu_irq}, 32'h0);
        check("R10 dev_rst after reset", {29'b0, dev_rst}, 32'h0);
        check("R10 unlock after reset", {31'b0, cmos_wr_ok}, 32'h0);
        rd(9, v); check("R10 status after reset", v, 32'h0);
    endtask

    task automatic t_revision();
        logic [31:0] v;
        do_reset();
        wr(0, 32'h0000_0055, 4'hF);
        rd(0, v); check("R2 revision read", v, 32'h1);
    endtask

    task automatic t_storage_and_hole();
        logic [31:0] v;
        do_reset();
        wr(10, 32'hCAFE_0001, 4'hF);
        rd(10, v); check("R1 size readback", v, 32'hCAFE_0001);
        wr(14, 32'h0BAD_F00D, 4'hF);
        rd(14, v); check("R1 trackball readback", v, 32'h0BAD_F00D);
        wr(6, 32'hFFFF_FFFF, 4'hF);
        rd(6, v); check("R1 unused reads zero", v, 32'h0);
        wr(9, 32'hFFFF_FFFF, 4'hF);
        rd(9, v); check("R1 status ignores write", v, 32'h0);
        wr(8, 32'hFFFF_FFFF, 4'hF);
        rd(8, v); check("R1 cause ignores write", v, 32'h0);
    endtask

    task automatic t_byte_merge();
        logic [31:0] v;
        do_reset();
        wr(11, 32'hAABB_CCDD, 4'hF);
        wr(11, 32'h1122_3344, 4'b0101);
        rd(11, v); check("R8 byte merge", v, 32'hAA22_CC44);
        wr(1, 32'h0000_0015, 4'hF);
        check("R8 dev_rst all", {29'b0, dev_rst}, 32'h7);
        wr(1, 32'h0000_0004, 4'hF);
        check("R8 dev_rst graphics only", {29'b0, dev_rst}, 32'h2);
    endtask

    task automatic t_raise_release();
        logic [31:0] v;
        do_reset();
        wr(3, 32'h1, 4'hF);
        wr(7, 32'h1F, 4'hF);
        src_irq[0] = 1'b1;
        step(1);
        rd(9, v); check("R3 status set on rise", v, 32'h1);
        check("R4 line not yet high", {29'b0, cpu_irq}, 32'h0);
        step(1);
        check("R4 line 0 raised", {29'b0, cpu_irq}, 32'h1);
        rd(8, v); check("R4 cause latched", v, 32'h1);
        src_irq[0] = 1'b0;
        step(1);
        rd(9, v); check("R3 status cleared on fall", v, 32'h0);
        rd(8, v); check("R3 cause cleared on fall", v, 32'h0);
        check("R5 line still high", {29'b0, cpu_irq}, 32'h1);
        step(1);
        check("R5 line released", {29'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_enable_ack();
        logic [31:0] v;
        do_reset();
        wr(4, 32'h18, 4'hF);
        wr(7, 32'h1F, 4'hF);
        src_irq[3] = 1'b1; src_irq[4] = 1'b1;
        step(2);
        check("R4 line 1 raised", {29'b0, cpu_irq}, 32'h2);
        wr(7, 32'h17, 4'hF);
        rd(8, v); check("R6 cause bit 3 acked", v, 32'h10);
        rd(9, v); check("R6 status kept", v, 32'h18);
        step(1);
        check("R5 held by other cause", {29'b0, cpu_irq}, 32'h2);
        wr(7, 32'h07, 4'hF);
        rd(8, v); check("R6 cause all acked", v, 32'h0);
        step(1);
        check("R5 line dropped after ack", {29'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_vsync_clear();
        logic [31:0] v;
        do_reset();
        wr(5, 32'h2, 4'hF);
        wr(7, 32'h2, 4'hF);
        wr(2, 32'h1, 4'hF);
        src_irq[1] = 1'b1;
        step(2);
        check("R4 line 2 raised", {29'b0, cpu_irq}, 32'h4);
        wr(2, 32'h2, 4'hF);
        rd(9, v); check("R7 vblank status cleared", v, 32'h0);
        rd(8, v); check("R7 vblank cause cleared", v, 32'h0);
        check("R7 polarity bit", {31'b0, vsync_pol}, 32'h1);
        step(1);
        check("R7 line 2 released", {29'b0, cpu_irq}, 32'h0);
        step(2);
        rd(9, v); check("R7 status stays clear while high", v, 32'h0);
    endtask

    task automatic t_unlock();
        logic [31:0] v;
        do_reset();
        rd(12, v); check("R9 locked at start", v, 32'h0);
        wr(12, 32'h0, 4'hF);
        check("R9 unlock set", {31'b0, cmos_wr_ok}, 32'h1);
        wr(12, 32'h0, 4'hF);
        step(3);
        rd(12, v); check("R9 unlock sticky", v, 32'h1);
    endtask

    task automatic t_reset_clears();
        logic [31:0] v;
        do_reset();
        wr(11, 32'h1234_5678, 4'hF);
        wr(12, 32'h1, 4'hF);
        wr(3, 32'h4, 4'hF);
        wr(7, 32'h4, 4'hF);
        src_irq[2] = 1'b1;
        step(2);
        check("R4 line 0 from graphics", {29'b0, cpu_irq}, 32'h1);
        rst = 1'b1;
        step(1);
        rst = 1'b0; src_irq = '0;
        check("R10 irq cleared", {29'b0, cpu_irq}, 32'h0);
        check("R10 unlock cleared", {31'b0, cmos_wr_ok}, 32'h0);
        rd(11, v); check("R10 storage cleared", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R10 run timeout actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_revision();
        t_storage_and_hole();
        t_byte_merge();
        t_raise_release();
        t_enable_ack();
        t_vsync_clear();
        t_unlock();
        t_reset_clears();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule